// File: doc/BRIEF.md
# Address Tenure Controller (Bus Master Side)

This block runs the address phase of one transfer on a split-transaction bus, from the point of view of the bus master. A local client hands over an address and a set of transfer attributes. The controller then requests the address bus and waits for a grant. It opens the tenure with a single-cycle start strobe and keeps the address and attributes driven, with their output enable high, until a slave acknowledges.

The cycle after an accepted acknowledge is the release cycle. In that cycle the output enable drops, so the pads can float, and the controller samples the retry input. If retry is high, the controller requests the bus again and repeats the whole address phase with the same address and attributes once it has a fresh grant. If retry is low, it signals completion and returns to idle.

An acknowledge that comes too soon after the start strobe breaks the protocol. Such an acknowledge is reported on an error output and otherwise ignored. The data phase is handled elsewhere.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_req`, `ts_o`, `addr_oe`, `abb_o`, `done_o` and `proto_err_o` are low and `cmd_ready` is high.
- R2: A command is taken only in a cycle where `cmd_ready` is high and `cmd_valid` is high. Its address and attributes appear on `addr_o`/`attr_o` in every attempt of that tenure. `cmd_valid` is ignored, and `cmd_ready` is low, until the tenure completes.
- R3: `bus_req` is high from the cycle after a command is taken until the cycle in which `bus_grant` is sampled high. It is low in the strobe cycle. A grant while no request is pending starts nothing.
- R4: `ts_o` is high for exactly one cycle, the cycle right after `bus_grant` is sampled high during a request.
- R5: `addr_oe` and `abb_o` go high together with `ts_o` and stay high in every cycle until an acknowledge is accepted.
- R6: `aack_i` is accepted only when at least 2 cycles (parameter `MIN_ACK_GAP`) have passed since the strobe cycle. An earlier acknowledge gives a one-cycle `proto_err_o` pulse in the following cycle and the tenure continues unchanged.
- R7: In the cycle after an accepted acknowledge (the release cycle), `addr_oe` and `abb_o` are low and `artry_i` is sampled.
- R8: If `artry_i` is high in the release cycle, `bus_req` is high in the next cycle, no `done_o` is given, and a new strobe waits for a new grant.
- R9: If `artry_i` is low in the release cycle, `done_o` is high for exactly the next cycle, and `cmd_ready` is high from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Client offers a new tenure |
| cmd_addr | input | ADDR_W | Address of the offered tenure |
| cmd_attr | input | ATTR_W | Transfer attributes of the offered tenure |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| bus_req | output | 1 | Address bus request to the arbiter |
| bus_grant | input | 1 | Address bus grant from the arbiter |
| ts_o | output | 1 | Transfer-start strobe |
| addr_o | output | ADDR_W | Address driven on the bus |
| attr_o | output | ATTR_W | Attributes driven on the bus |
| addr_oe | output | 1 | Enable for the address and attribute pad drivers |
| abb_o | output | 1 | Address bus busy |
| aack_i | input | 1 | Address acknowledge from a slave |
| artry_i | input | 1 | Address retry |
| done_o | output | 1 | Tenure completed without retry |
| proto_err_o | output | 1 | Acknowledge arrived too early |

## Verification
The bench places the acknowledge at exactly the minimum gap and also further out. It injects early acknowledges in the strobe cycle and in the cycle after it. A design with an off-by-one age counter would either release the bus on an illegal acknowledge or miss the legal one. Retry chains of several attempts check that the same address comes back after a new grant. A controller that skipped re-arbitration, pulsed done on a retry, or captured a command offered during the tenure would show the wrong strobe timing or a corrupted address. Grants offered while idle and commands offered mid-tenure check that stray inputs start nothing.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_START = 3'd2,
    ST_WAIT  = 3'd3,
    ST_REL   = 3'd4
  } atc_state_e;
endpackage

// File: rtl/atc_ack_window.sv
// Tracks cycles since the transfer-start strobe and classifies each
// acknowledge as acceptable or premature.
module atc_ack_window #(
  parameter int MIN_ACK_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ts_active,
  input  logic wait_active,
  input  logic aack_i,
  output logic ack_ok,
  output logic proto_err_o
);
  localparam int AGE_W = $clog2(MIN_ACK_GAP + 1);
  localparam logic [AGE_W-1:0] GAP = AGE_W'(MIN_ACK_GAP);

  logic [AGE_W-1:0] age_q, age_d;
  logic             age_en;
  logic             young;
  logic             early;
  logic             err_q;

  assign young  = wait_active && (age_q < GAP);
  assign age_en = ts_active || young;
  assign age_d  = ts_active ? AGE_W'(1) : age_q + AGE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  assign ack_ok = wait_active && aack_i && !young;
  assign early  = aack_i && (ts_active || young);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= early;
    end
  end

  assign proto_err_o = err_q;

  AST_NO_ACK_AFTER_TS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |-> !$past(ts_active)); // R6
  AST_OK_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> !proto_err_o); // R6
endmodule

// File: rtl/atc_addr_hold.sv
// Captures address and attributes when a command is taken; holds them
// across every attempt of the tenure.
module atc_addr_hold #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drive_en,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ATTR_W-1:0] cmd_attr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ATTR_W-1:0] attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      attr_q <= '0;
    end else if (load) begin
      addr_q <= cmd_addr;
      attr_q <= cmd_attr;
    end
  end

  assign addr_o = addr_q;
  assign attr_o = attr_q;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en)) |-> ($stable(addr_o) && $stable(attr_o))); // R2
  AST_NO_LOAD_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !load); // R2
endmodule

// File: rtl/atc_tenure_fsm.sv
// Sequencer: request, strobe, hold, release, retry-or-done.
module atc_tenure_fsm
  import atc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic bus_grant,
  input  logic ack_ok,
  input  logic artry_i,
  output logic cmd_ready,
  output logic load,
  output logic bus_req,
  output logic ts_active,
  output logic wait_active,
  output logic drive_en,
  output logic done_o
);
  atc_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_REQ;
      ST_REQ:   if (bus_grant) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (ack_ok) state_d = ST_REL;
      ST_REL:   state_d = artry_i ? ST_REQ : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign done_d = (state_q == ST_REL) && !artry_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign load        = cmd_ready && cmd_valid;
  assign bus_req     = (state_q == ST_REQ);
  assign ts_active   = (state_q == ST_START);
  assign wait_active = (state_q == ST_WAIT);
  assign drive_en    = ts_active || wait_active;
  assign done_o      = done_q;

  AST_TS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_active |=> !ts_active); // R4
  AST_TS_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ts_active |-> $past(bus_req && bus_grant)); // R4
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !ack_ok) |=> drive_en); // R5
  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en) |-> $past(ack_ok)); // R7
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int ATTR_W      = 5,
  parameter int MIN_ACK_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ATTR_W-1:0] cmd_attr,
  output logic              cmd_ready,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              ts_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic              addr_oe,
  output logic              abb_o,
  input  logic              aack_i,
  input  logic              artry_i,
  output logic              done_o,
  output logic              proto_err_o
);
  logic load, ts_active, wait_active, drive_en, ack_ok;

  atc_tenure_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .bus_grant   (bus_grant),
    .ack_ok      (ack_ok),
    .artry_i     (artry_i),
    .cmd_ready   (cmd_ready),
    .load        (load),
    .bus_req     (bus_req),
    .ts_active   (ts_active),
    .wait_active (wait_active),
    .drive_en    (drive_en),
    .done_o      (done_o)
  );

  atc_ack_window #(.MIN_ACK_GAP(MIN_ACK_GAP)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_active   (ts_active),
    .wait_active (wait_active),
    .aack_i      (aack_i),
    .ack_ok      (ack_ok),
    .proto_err_o (proto_err_o)
  );

  atc_addr_hold #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .drive_en (drive_en),
    .cmd_addr (cmd_addr),
    .cmd_attr (cmd_attr),
    .addr_o   (addr_o),
    .attr_o   (attr_o)
  );

  assign ts_o    = ts_active;
  assign addr_oe = drive_en;
  assign abb_o   = drive_en;

  AST_DONE_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !$past(artry_i)); // R9
  AST_RETRY_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(addr_oe) && artry_i) |=> (bus_req && !done_o)); // R8
endmodule

// File: tb/tb_addr_tenure_ctrl.sv
module tb_addr_tenure_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int TW = 5;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, bus_grant, aack_i, artry_i;
  logic [AW-1:0] cmd_addr;
  logic [TW-1:0] cmd_attr;
  logic cmd_ready, bus_req, ts_o, addr_oe, abb_o, done_o, proto_err_o;
  logic [AW-1:0] addr_o;
  logic [TW-1:0] attr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_tenure_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_attr(cmd_attr), .cmd_ready(cmd_ready), .bus_req(bus_req),
    .bus_grant(bus_grant), .ts_o(ts_o), .addr_o(addr_o), .attr_o(attr_o),
    .addr_oe(addr_oe), .abb_o(abb_o), .aack_i(aack_i), .artry_i(artry_i),
    .done_o(done_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit early_flag(input int c, input int early_at);
    return (c == early_at);
  endfunction

  task automatic tenure(input logic [AW-1:0] a, input logic [TW-1:0] t_attr,
                        input int gd, input int t, input int nret,
                        input int early_at, input bit noise);
    cmd_valid = 1'b1; cmd_addr = a; cmd_attr = t_attr;
    chk("R2", "ready at offer", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int at = 0; at <= nret; at++) begin
      chk(at == 0 ? "R3" : "R8", "req pending", bus_req, 1);
      chk("R4", "no strobe before grant", ts_o, 0);
      for (int g = 0; g < gd; g++) begin
        @(negedge clk);
        chk("R3", "req held", bus_req, 1);
        chk("R4", "strobe waits grant", ts_o, 0);
      end
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      chk("R4", "strobe", ts_o, 1);
      chk("R5", "oe at strobe", addr_oe, 1);
      chk("R5", "busy at strobe", abb_o, 1);
      chk("R2", "addr", addr_o, a);
      chk("R2", "attr", attr_o, t_attr);
      chk("R3", "req drops", bus_req, 0);
      for (int c = 0; c < t; c++) begin
        aack_i = early_flag(c, early_at);
        if (noise) begin cmd_valid = 1'b1; cmd_addr = ~a; cmd_attr = ~t_attr; end
        @(negedge clk);
        aack_i = 1'b0; cmd_valid = 1'b0;
        chk("R4", "strobe single", ts_o, 0);
        chk("R5", "oe held", addr_oe, 1);
        chk("R5", "busy held", abb_o, 1);
        chk("R2", "addr held", addr_o, a);
        chk("R2", "busy not ready", cmd_ready, 0);
        chk("R6", "early err", proto_err_o, early_flag(c, early_at));
      end
      aack_i = 1'b1;
      @(negedge clk);
      aack_i = 1'b0;
      artry_i = (at < nret);
      chk("R7", "oe released", addr_oe, 0);
      chk("R7", "busy released", abb_o, 0);
      chk("R6", "no err on legal ack", proto_err_o, 0);
      chk("R9", "no done in release", done_o, 0);
      @(negedge clk);
      artry_i = 1'b0;
      if (at < nret) begin
        chk("R8", "no done on retry", done_o, 0);
      end else begin
        chk("R9", "done", done_o, 1);
        chk("R9", "ready after done", cmd_ready, 1);
      end
    end
    @(negedge clk);
    chk("R9", "done single", done_o, 0);
    chk("R9", "idle ready", cmd_ready, 1);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_attr = '0;
    bus_grant = 1'b0; aack_i = 1'b0; artry_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "req in reset", bus_req, 0);
    chk("R1", "ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ts", ts_o, 0);
    chk("R1", "oe", addr_oe, 0);
    chk("R1", "busy", abb_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "err", proto_err_o, 0);
    chk("R1", "ready", cmd_ready, 1);

    // R3: grant and acknowledge while idle start nothing
    bus_grant = 1'b1; aack_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R3", "idle grant no req", bus_req, 0);
      chk("R3", "idle grant no strobe", ts_o, 0);
      chk("R3", "idle grant no drive", addr_oe, 0);
    end
    bus_grant = 1'b0; aack_i = 1'b0;
    @(negedge clk);

    // directed corner cases
    tenure(32'hDEAD_BEEF, 5'h15, 0, 2, 0, -1, 1'b0); // ack at minimum gap
    tenure(32'h1234_5678, 5'h0A, 1, 3, 0,  0, 1'b1); // early ack in strobe cycle
    tenure(32'hCAFE_0001, 5'h1F, 2, 2, 0,  1, 1'b0); // early ack one cycle later
    tenure(32'h0BAD_F00D, 5'h03, 0, 4, 3, -1, 1'b1); // retry chain

    for (int i = 0; i < 60; i++) begin
      int t  = 2 + int'($urandom_range(0, 5));
      int ea = int'($urandom_range(0, 3));
      tenure($urandom, 5'($urandom), int'($urandom_range(0, 4)), t,
             int'($urandom_range(0, 2)), (ea < 2) ? ea : -1,
             1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule